// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

This block is a register-mapped real-time-clock core. It keeps a 32-bit binary count of seconds. The count advances from a prescaler that divides a 32.768 kHz clock-enable input down to one step per second. A 32-bit alarm value is compared against the count. The core raises two sticky event flags: one on each seconds increment, and one when the alarm value is reached. Each flag has its own interrupt enable, and a single level interrupt output combines them. A 32-bit scratch register holds any value software stores in it.

Every register write is protected twice. First, software must arm a write unlock by storing a key value in a dedicated unlock register. Second, the write is taken only while a ready bit is high. After each accepted write, the ready bit drops for a set number of cycles, and the unlock disarms. A read-modify-write of the control word must write 1 to each event flag it wants to keep, because an event flag clears only when 0 is written to it.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the seconds, alarm, scratch and unlock registers read 0, the control word at 0x00 reads 0x80 (only ready set), and irq is low.
- R2: While control bit 0 (run) is set, the seconds register at 0x04 gains 1 after every 2^PRE_W clock edges on which tick_32k is high. With tick_32k low, or with run clear, it holds its value. Clearing run also resets the prescaler.
- R3: A write to 0x04 loads the full 32-bit seconds value, and counting from 0xFFFFFFFF wraps to 0.
- R4: A write of 0x0000A55A to 0x3C sets bit 31 of that register (write unlocked). A write of any other value leaves it unchanged.
- R5: While the register at 0x3C has bit 31 clear, writes to every other address leave the register contents unchanged.
- R6: An accepted write to any address other than 0x3C clears bit 31 of 0x3C, so every write needs a new unlock.
- R7: Control bit 7 (ready) reads 0 for exactly READY_HOLD cycles after an accepted write. A write attempted while it is 0 is dropped and leaves the unlock armed.
- R8: Control bit 6 (second flag) sets on every seconds increment. A load through 0x04 does not set it.
- R9: Control bit 4 (alarm flag) sets when control bit 2 (alarm enable) is set and the seconds register changes, by increment or by load, to the value of the alarm register at 0x08. With bit 2 clear it does not set.
- R10: A write to the control word clears bit 6 or bit 4 where the written bit is 0 and leaves that flag unchanged where the written bit is 1. A flag set event in the same cycle wins over the clear.
- R11: irq is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of the control word are set.
- R12: The scratch register at 0x34 holds and returns any 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | 32.768 kHz clock enable feeding the prescaler |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench counts the ready-low window edge by edge. A design that reopened ready one cycle early or late would show the wrong bit 7 on the boundary cycle. It sends a write into that window and confirms that the write is dropped and the unlock stays armed. A design that consumed the unlock on a dropped write would read 0 at 0x3C.

It checks the exact edge on which the count steps and wraps from all-ones, and confirms that loading the count does not set the second flag. It checks that the alarm fires on a load-made match only when the alarm is enabled. Writing 1 to a flag must keep it, and writing 0 must clear it. An inverted clear rule would lose a pending alarm, or leave irq stuck high.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 6;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_SECS = 6'h04;
   localparam logic [ADDR_W-1:0] OFS_ALRM = 6'h08;
   localparam logic [ADDR_W-1:0] OFS_SCRA = 6'h34;
   localparam logic [ADDR_W-1:0] OFS_UNLK = 6'h3C;

   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_AEN  = 2;
   localparam int unsigned B_AIE  = 3;
   localparam int unsigned B_AFL  = 4;
   localparam int unsigned B_SIE  = 5;
   localparam int unsigned B_SFL  = 6;
   localparam int unsigned B_RDY  = 7;
   localparam int unsigned B_UNLK = 31;

   localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

   localparam int unsigned FLAG_N   = 2;
   localparam int unsigned FLG_SEC  = 0;
   localparam int unsigned FLG_ALM  = 1;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned PRE_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic step,
   output logic wrap
);
   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = run & step & (&cnt_q);
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
   import rtc_pkg::*;
#(
   parameter int unsigned HOLD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic              acc,
   output logic              armed,
   output logic              ready
);
   logic key_hit;

   assign key_hit = we && (addr == OFS_UNLK) && (wdata == UNLOCK_KEY);
   assign acc     = we && (addr != OFS_UNLK) && armed && ready;

   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= 1'b0;
      else if (acc)     armed <= 1'b0;
      else if (key_hit) armed <= 1'b1;
   end

   generate
      if (HOLD == 0) begin : g_no_busy
         assign ready = 1'b1;
      end else begin : g_busy
         localparam int unsigned CW = $clog2(HOLD + 1);
         logic [CW-1:0] busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              busy_q <= '0;
            else if (acc)            busy_q <= CW'(HOLD);
            else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
         end
         assign ready = (busy_q == '0);
      end
   endgenerate
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         wr,
   input  logic [N-1:0] keep,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)              flag[i] <= 1'b0;
            else if (set[i])         flag[i] <= 1'b1;
            else if (wr && !keep[i]) flag[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
   import rtc_pkg::*;
#(
   parameter int unsigned PRE_W      = 15,
   parameter int unsigned READY_HOLD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              irq
);
   generate
      if (PRE_W < 2 || PRE_W > 24) begin : g_bad_pre
         $error("rtc_sec_alarm: PRE_W out of range");
      end
      if (READY_HOLD > 255) begin : g_bad_hold
         $error("rtc_sec_alarm: READY_HOLD out of range");
      end
   endgenerate

   logic              acc, unlk_q, wr_ready, sec_tick;
   logic              run_q, aen_q, aie_q, sie_q;
   logic [REG_W-1:0]  sec_q, alm_q, scr_q, sec_nxt;
   logic              wr_ctrl, wr_sec, wr_alm, wr_scr, sec_chg;
   logic [FLAG_N-1:0] flg_set, flg_keep, flg;
   logic              sfl, afl;

   rtc_wr_gate #(.HOLD(READY_HOLD)) u_gate (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .acc(acc), .armed(unlk_q), .ready(wr_ready)
   );

   rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .step(tick_32k), .wrap(sec_tick)
   );

   assign wr_ctrl = acc && (bus_addr == OFS_CTRL);
   assign wr_sec  = acc && (bus_addr == OFS_SECS);
   assign wr_alm  = acc && (bus_addr == OFS_ALRM);
   assign wr_scr  = acc && (bus_addr == OFS_SCRA);

   // a load takes priority over a same-cycle increment
   assign sec_nxt = wr_sec ? bus_wdata : sec_q + 32'd1;
   assign sec_chg = wr_sec | sec_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0;
         alm_q <= '0;
         scr_q <= '0;
         run_q <= 1'b0;
         aen_q <= 1'b0;
         aie_q <= 1'b0;
         sie_q <= 1'b0;
      end else begin
         if (sec_chg) sec_q <= sec_nxt;
         if (wr_alm)  alm_q <= bus_wdata;
         if (wr_scr)  scr_q <= bus_wdata;
         if (wr_ctrl) begin
            run_q <= bus_wdata[B_RUN];
            aen_q <= bus_wdata[B_AEN];
            aie_q <= bus_wdata[B_AIE];
            sie_q <= bus_wdata[B_SIE];
         end
      end
   end

   assign flg_set[FLG_SEC]  = sec_tick & ~wr_sec;
   assign flg_set[FLG_ALM]  = aen_q & sec_chg & (sec_nxt == alm_q);
   assign flg_keep[FLG_SEC] = bus_wdata[B_SFL];
   assign flg_keep[FLG_ALM] = bus_wdata[B_AFL];

   rtc_evt_flags #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flg_set), .wr(wr_ctrl), .keep(flg_keep), .flag(flg)
   );

   assign sfl = flg[FLG_SEC];
   assign afl = flg[FLG_ALM];
   assign irq = (sfl & sie_q) | (afl & aie_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[B_RUN] = run_q;
            bus_rdata[B_AEN] = aen_q;
            bus_rdata[B_AIE] = aie_q;
            bus_rdata[B_AFL] = afl;
            bus_rdata[B_SIE] = sie_q;
            bus_rdata[B_SFL] = sfl;
            bus_rdata[B_RDY] = wr_ready;
         end
         OFS_SECS: bus_rdata = sec_q;
         OFS_ALRM: bus_rdata = alm_q;
         OFS_SCRA: bus_rdata = scr_q;
         OFS_UNLK: bus_rdata[B_UNLK] = unlk_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
   import rtc_pkg::*;
#(
   parameter int unsigned HOLD = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic              acc,
   input logic              unlk_q,
   input logic              wr_ready,
   input logic              sec_tick,
   input logic [REG_W-1:0]  sec_q,
   input logic              sfl,
   input logic              afl,
   input logic              aen_q
);
   p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !unlk_q);

   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (HOLD > 0 && acc) |=> !wr_ready);

   p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_SECS && !unlk_q && !sec_tick) |=> (sec_q == $past(sec_q)));

   p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !(acc && bus_addr == OFS_SECS)) |=> (sec_q == $past(sec_q) + 32'd1));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sfl && !(acc && bus_addr == OFS_CTRL && !bus_wdata[B_SFL])) |=> sfl);

   p_alarm_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(afl) |-> $past(aen_q));
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.HOLD(READY_HOLD)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .acc(acc), .unlk_q(unlk_q), .wr_ready(wr_ready), .sec_tick(sec_tick), .sec_q(sec_q),
   .sfl(sfl), .afl(afl), .aen_q(aen_q)
);

// File: tb/rtc_sec_alarm_test.sv
`timescale 1ns/1ps
module rtc_sec_alarm_test;
   localparam int unsigned PW   = 6;
   localparam int unsigned HOLD = 4;
   localparam int unsigned SEC_CYC = 1 << PW;

   localparam logic [5:0] A_CTRL = 6'h00, A_SECS = 6'h04, A_ALRM = 6'h08,
                          A_SCRA = 6'h34, A_UNLK = 6'h3C;
   localparam logic [31:0] KEY = 32'h0000_A55A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_32k = 1'b1;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rtc_sec_alarm #(.PRE_W(PW), .READY_HOLD(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wr_raw(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic wait_ready();
      logic [31:0] v;
      for (int i = 0; i < 20; i++) begin
         rd(A_CTRL, v);
         if (v[7]) break;
         @(negedge clk);
      end
   endtask

   task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
      wait_ready();
      wr_raw(A_UNLK, KEY);
      wr_raw(a, d);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); check("R1 ctrl", v, 32'h80);
      rd(A_SECS, v); check("R1 secs", v, 0);
      rd(A_ALRM, v); check("R1 alarm", v, 0);
      rd(A_SCRA, v); check("R1 scratch", v, 0);
      rd(A_UNLK, v); check("R1 unlock", v, 0);
      check("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_locked();
      logic [31:0] v;
      wr_raw(A_SECS, 32'h1234);
      wr_raw(A_SCRA, 32'h5);
      rd(A_SECS, v); check("R5 secs locked", v, 0);
      rd(A_SCRA, v); check("R5 scratch locked", v, 0);
      wr_raw(A_UNLK, 32'h1111);
      rd(A_UNLK, v); check("R4 bad key", v, 0);
      wr_raw(A_UNLK, KEY);
      rd(A_UNLK, v); check("R4 good key", v, 32'h8000_0000);
   endtask

   task automatic t_scratch_ready();
      logic [31:0] v;
      reg_write(A_SCRA, 32'hDEAD_BEEF);
      rd(A_SCRA, v); check("R12 scratch", v, 32'hDEAD_BEEF);
      rd(A_UNLK, v); check("R6 relocked", v, 0);
      rd(A_CTRL, v); check("R7 ready low", {31'd0, v[7]}, 0);
      repeat (HOLD - 1) @(negedge clk);
      rd(A_CTRL, v); check("R7 ready last low", {31'd0, v[7]}, 0);
      @(negedge clk);
      rd(A_CTRL, v); check("R7 ready back", {31'd0, v[7]}, 1);
   endtask

   task automatic t_dropped();
      logic [31:0] v;
      reg_write(A_SCRA, 32'h0000_00AA);
      wr_raw(A_UNLK, KEY);
      wr_raw(A_SCRA, 32'h0000_0055);
      rd(A_SCRA, v); check("R7 busy write dropped", v, 32'h0000_00AA);
      rd(A_UNLK, v); check("R7 unlock kept", v, 32'h8000_0000);
   endtask

   task automatic t_count();
      logic [31:0] v;
      reg_write(A_SECS, 32'hFFFF_FFFF);
      rd(A_CTRL, v); check("R8 load no flag", {31'd0, v[6]}, 0);
      reg_write(A_CTRL, 32'h01);
      repeat (SEC_CYC - 1) @(negedge clk);
      rd(A_SECS, v); check("R2 before step", v, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(A_SECS, v); check("R3 wrap", v, 0);
      rd(A_CTRL, v); check("R8 sec flag", {31'd0, v[6]}, 1);
      check("R11 irq masked", {31'd0, irq}, 0);
      reg_write(A_CTRL, 32'h60);
      check("R11 irq sec", {31'd0, irq}, 1);
      rd(A_CTRL, v); check("R10 keep sec flag", {31'd0, v[6]}, 1);
      reg_write(A_CTRL, 32'h20);
      rd(A_CTRL, v); check("R10 clear sec flag", {31'd0, v[6]}, 0);
      check("R11 irq off", {31'd0, irq}, 0);
   endtask

   task automatic t_gating();
      logic [31:0] v, hold_v;
      tick_32k = 1'b0;
      reg_write(A_CTRL, 32'h01);
      repeat (200) @(negedge clk);
      rd(A_SECS, v); check("R2 no tick", v, 0);
      tick_32k = 1'b1;
      repeat (SEC_CYC + 6) @(negedge clk);
      rd(A_SECS, v); check("R2 tick resumes", v, 1);
      reg_write(A_CTRL, 32'h00);
      rd(A_SECS, hold_v);
      repeat (200) @(negedge clk);
      rd(A_SECS, v); check("R2 run clear holds", v, hold_v);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      reg_write(A_SECS, 32'd10);
      reg_write(A_ALRM, 32'd12);
      reg_write(A_CTRL, 32'h0D);
      repeat (2 * SEC_CYC - 1) @(negedge clk);
      rd(A_SECS, v); check("R2 secs 11", v, 32'd11);
      rd(A_CTRL, v); check("R9 not yet", {31'd0, v[4]}, 0);
      @(negedge clk);
      rd(A_SECS, v); check("R2 secs 12", v, 32'd12);
      rd(A_CTRL, v); check("R9 alarm hit", {31'd0, v[4]}, 1);
      check("R11 irq alarm", {31'd0, irq}, 1);
      reg_write(A_CTRL, 32'h1C);
      rd(A_CTRL, v); check("R10 keep alarm", v & 32'h7F, 32'h1C);
      check("R11 irq held", {31'd0, irq}, 1);
      reg_write(A_CTRL, 32'h0C);
      rd(A_CTRL, v); check("R10 clear alarm", v & 32'h7F, 32'h0C);
      check("R11 irq cleared", {31'd0, irq}, 0);
      reg_write(A_CTRL, 32'h00);
      reg_write(A_SECS, 32'd12);
      rd(A_CTRL, v); check("R9 disabled no flag", v & 32'h7F, 32'h00);
      reg_write(A_CTRL, 32'h04);
      reg_write(A_SECS, 32'd12);
      rd(A_CTRL, v); check("R9 load match", v & 32'h7F, 32'h14);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_scratch_ready();
      t_dropped();
      t_count();
      t_gating();
      t_alarm();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule